// File: doc/BRIEF.md
# Run-Time Programmable Parallel CRC Engine

This block folds one data word of up to 32 bits into a running cyclic redundancy check on every clock cycle in which the word is marked valid. The generator polynomial is not fixed when the block is built. It lives in a grid of small cells, one per pair of (CRC row, input column). Each cell holds a single stored bit, and that bit decides whether the cell XORs its column input into the row's running value or passes the row value through unchanged. A host loads the grid one column at a time over a shared data bus, using a one-hot column select. Any polynomial of degree 1 to 32 can then be run.

A CRC-width setting takes care of polynomials shorter than the grid. It lines up the fed-back remainder with the input columns and masks the result. A per-word byte-count setting lets the final word of a message carry only 8, 16, 24 or 32 valid bits. The unused upper input bits are forced to zero, and the previous remainder is shifted so that only the valid bits are absorbed. A start pulse seeds the remainder with a programmable initial value. One cycle after the last word is accepted, the finished remainder is shown on the output together with a done strobe.

The CRC is non-reflected and has no final XOR. Within a word, bits are absorbed from the most significant valid bit downward.

Top module: `crc_prog_engine`

## Requirements
- R1: Each grid cell passes its row input through when its stored bit is 0 and outputs row input XOR column input when it is 1. With column j holding the coefficients of x^(n+j) mod G (row i = coefficient of x^i), each accepted full word d updates the remainder to (crc·x^32 + d·x^n) mod G.
- R2: A cell's stored bit is written from `cfg_data[row]` only in a cycle where `cfg_col_en[column]` is 1. Changes on `cfg_data` while `cfg_col_en` is zero leave the polynomial unchanged.
- R3: The remainder changes only when `start` or `in_valid` is high. `in_data` and `in_last` are ignored while `in_valid` is low.
- R4: A `start` without `in_valid` loads the remainder with `init_value` masked to the CRC width, and that value is visible on `crc_out` in the next cycle.
- R5: A `start` together with `in_valid` absorbs that word into `init_value`, discarding the previous remainder.
- R6: The CRC width is n = `crc_len_m1`+1. `crc_out` bits at positions n and above are always 0, and polynomials of width 5, 8, 16 and 32 give correct remainders.
- R7: A word with `in_bytes_m1` = b absorbs only `in_data[8(b+1)-1:0]`, MSB first, giving (crc·x^k + d·x^n) mod G with k = 8(b+1). Bits above k have no effect.
- R8: `crc_done` is 1 exactly in the cycle after a word with `in_valid` and `in_last` both high, and `crc_out` then holds the final remainder.
- R9: Reset clears the remainder, `crc_done` and every stored cell bit. An unprogrammed grid with n=32 therefore yields a remainder of 0 for a full word.
- R10: `cfg_col_en` has at most one bit set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_col_en | input | 32 | One-hot column write select for the cell grid |
| cfg_data | input | 32 | Broadcast column configuration bits, one per row |
| crc_len_m1 | input | 5 | CRC width minus one |
| init_value | input | 32 | Seed loaded by `start` |
| start | input | 1 | Begin a new message |
| in_valid | input | 1 | Input word is valid this cycle |
| in_last | input | 1 | Input word is the last of the message |
| in_bytes_m1 | input | 2 | Valid bytes in the word minus one (low bytes) |
| in_data | input | 32 | Input word |
| crc_out | output | 32 | Remainder masked to the CRC width |
| crc_done | output | 1 | Final remainder is on `crc_out` this cycle |

## Verification
The seed load and the absorption of a word can fall in the same cycle. When `start` and `in_valid` coincide, the word must be folded into the seed rather than into the remainder left over from the previous message. The bench provokes this by opening every two-word message with `start` and the first word together, right after a completed message has left a non-zero remainder. The result is judged against a bit-serial shift-register reference that starts from the seed. A second overlap, a partial final word whose k is smaller than the CRC width, routes part of the old remainder past the grid. It is judged the same way for k = 8 with widths 16 and 32.

// File: rtl/crc_prog_pkg.sv
package crc_prog_pkg;
  localparam int unsigned BYTE_SHIFT = 3;
endpackage

// File: rtl/crc_prog_cell.sv
module crc_prog_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic cfg_bit,
  input  logic pass_in,
  input  logic tap_in,
  output logic cell_out
);
  logic sel_q;
  logic sel_d;

  always_comb begin
    sel_d = cfg_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
    end else if (cfg_we) begin
      sel_q <= sel_d;
    end
  end

  assign cell_out = sel_q ? (pass_in ^ tap_in) : pass_in;
endmodule

// File: rtl/crc_prog_array.sv
module crc_prog_array #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CRC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] col_en,
  input  logic [CRC_W-1:0]  cfg_data,
  input  logic [DATA_W-1:0] col_in,
  output logic [CRC_W-1:0]  row_out
);
  for (genvar r = 0; r < CRC_W; r++) begin : g_row
    logic [DATA_W:0] link;
    assign link[0] = 1'b0;
    for (genvar c = 0; c < DATA_W; c++) begin : g_col
      crc_prog_cell u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (col_en[c]),
        .cfg_bit  (cfg_data[r]),
        .pass_in  (link[c]),
        .tap_in   (col_in[c]),
        .cell_out (link[c+1])
      );
    end
    assign row_out[r] = link[DATA_W];
  end
endmodule

// File: rtl/crc_prog_feed.sv
module crc_prog_feed
  import crc_prog_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CRC_W  = 32,
  localparam int unsigned LW    = $clog2(CRC_W),
  localparam int unsigned BW    = $clog2(DATA_W / 8),
  localparam int unsigned PW    = DATA_W + CRC_W,
  localparam int unsigned SHW   = $clog2(PW + 1)
) (
  input  logic [CRC_W-1:0]  crc_base,
  input  logic [DATA_W-1:0] in_data,
  input  logic [LW-1:0]     len_m1,
  input  logic [BW-1:0]     bytes_m1,
  output logic [DATA_W-1:0] col_in,
  output logic [CRC_W-1:0]  row_bypass,
  output logic [CRC_W-1:0]  len_mask
);
  logic [SHW-1:0]    n_bits;
  logic [SHW-1:0]    k_bits;
  logic [PW-1:0]     p_shift;
  logic [DATA_W-1:0] col_fb;

  always_comb begin
    n_bits = SHW'(len_m1) + SHW'(1);
    k_bits = (SHW'(bytes_m1) + SHW'(1)) << BYTE_SHIFT;
  end

  for (genvar r = 0; r < CRC_W; r++) begin : g_mask
    assign len_mask[r] = (n_bits > SHW'(r));
  end

  // old remainder times x^k, split into the part that still needs reducing
  // (columns) and the part already below degree n (rows)
  assign p_shift    = PW'(crc_base & len_mask) << k_bits;
  assign col_fb     = DATA_W'(p_shift >> n_bits);
  assign row_bypass = p_shift[CRC_W-1:0] & len_mask;

  for (genvar c = 0; c < DATA_W; c++) begin : g_col
    assign col_in[c] = (in_data[c] & (k_bits > SHW'(c))) ^ col_fb[c];
  end
endmodule

// File: rtl/crc_prog_engine.sv
module crc_prog_engine #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CRC_W  = 32,
  localparam int unsigned LW    = $clog2(CRC_W),
  localparam int unsigned BW    = $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cfg_col_en,
  input  logic [CRC_W-1:0]  cfg_data,
  input  logic [LW-1:0]     crc_len_m1,
  input  logic [CRC_W-1:0]  init_value,
  input  logic              start,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic [BW-1:0]     in_bytes_m1,
  input  logic [DATA_W-1:0] in_data,
  output logic [CRC_W-1:0]  crc_out,
  output logic              crc_done
);
  logic [CRC_W-1:0]  crc_q;
  logic [CRC_W-1:0]  crc_d;
  logic              crc_en;
  logic              done_q;
  logic              done_d;
  logic [CRC_W-1:0]  base;
  logic [DATA_W-1:0] col_in;
  logic [CRC_W-1:0]  row_bypass;
  logic [CRC_W-1:0]  len_mask;
  logic [CRC_W-1:0]  row_out;

  assign base = start ? init_value : crc_q;

  crc_prog_feed #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_feed (
    .crc_base   (base),
    .in_data    (in_data),
    .len_m1     (crc_len_m1),
    .bytes_m1   (in_bytes_m1),
    .col_in     (col_in),
    .row_bypass (row_bypass),
    .len_mask   (len_mask)
  );

  crc_prog_array #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .col_en   (cfg_col_en),
    .cfg_data (cfg_data),
    .col_in   (col_in),
    .row_out  (row_out)
  );

  always_comb begin
    crc_en = start | in_valid;
    done_d = in_valid & in_last;
    if (in_valid) begin
      crc_d = (row_out ^ row_bypass) & len_mask;
    end else begin
      crc_d = base & len_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (crc_en) begin
        crc_q <= crc_d;
      end
      done_q <= done_d;
    end
  end

  assign crc_out  = crc_q & len_mask;
  assign crc_done = done_q;
endmodule

// File: rtl/crc_prog_checker.sv
module crc_prog_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CRC_W  = 32,
  localparam int unsigned LW    = $clog2(CRC_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] cfg_col_en,
  input logic [LW-1:0]     crc_len_m1,
  input logic [CRC_W-1:0]  init_value,
  input logic              start,
  input logic              in_valid,
  input logic              in_last,
  input logic [CRC_W-1:0]  crc_q,
  input logic [CRC_W-1:0]  crc_out,
  input logic              crc_done
);
  logic [CRC_W-1:0] chk_mask;
  for (genvar r = 0; r < CRC_W; r++) begin : g_m
    assign chk_mask[r] = (crc_len_m1 >= LW'(r));
  end

  a_r10_one_column: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cfg_col_en));

  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> crc_done);

  a_r8_done_only_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_last) |=> !crc_done);

  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !in_valid) |=> (crc_q == $past(crc_q)));

  a_r4_start_seeds: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !in_valid) |=> (crc_q == $past(init_value & chk_mask)));

  a_r6_out_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ((crc_out & ~chk_mask) == '0));
endmodule

bind crc_prog_engine crc_prog_checker #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_col_en (cfg_col_en),
  .crc_len_m1 (crc_len_m1),
  .init_value (init_value),
  .start      (start),
  .in_valid   (in_valid),
  .in_last    (in_last),
  .crc_q      (crc_q),
  .crc_out    (crc_out),
  .crc_done   (crc_done)
);

// File: tb/tb_crc_prog_engine.sv
module tb_crc_prog_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [31:0] cfg_col_en;
  logic [31:0] cfg_data;
  logic [4:0]  crc_len_m1;
  logic [31:0] init_value;
  logic        start;
  logic        in_valid;
  logic        in_last;
  logic [1:0]  in_bytes_m1;
  logic [31:0] in_data;
  logic [31:0] crc_out;
  logic        crc_done;

  int total = 0;
  int bad = 0;
  logic [31:0] seed = 32'h1BADF00D;

  crc_prog_engine dut (
    .clk(clk), .rst_n(rst_n), .cfg_col_en(cfg_col_en), .cfg_data(cfg_data),
    .crc_len_m1(crc_len_m1), .init_value(init_value), .start(start),
    .in_valid(in_valid), .in_last(in_last), .in_bytes_m1(in_bytes_m1),
    .in_data(in_data), .crc_out(crc_out), .crc_done(crc_done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] wmask(input int n);
    logic [63:0] m;
    m = (64'd1 << n) - 64'd1;
    return m[31:0];
  endfunction

  function automatic logic [31:0] mulx(input logic [31:0] v, input logic [31:0] poly, input int n);
    logic top;
    top = v[n-1];
    v = (v << 1) & wmask(n);
    if (top) v = v ^ (poly & wmask(n));
    return v;
  endfunction

  // bit-serial reference: k low bits of d, most significant first
  function automatic logic [31:0] ref_bits(input logic [31:0] crc, input logic [31:0] poly,
                                           input int n, input logic [31:0] d, input int k);
    for (int i = k - 1; i >= 0; i--) begin
      logic fb;
      fb = crc[n-1] ^ d[i];
      crc = (crc << 1) & wmask(n);
      if (fb) crc = crc ^ (poly & wmask(n));
    end
    return crc;
  endfunction

  function automatic logic [31:0] next_rand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic configure(input logic [31:0] poly, input int n);
    logic [31:0] v;
    crc_len_m1 = 5'(n - 1);
    v = poly & wmask(n);
    for (int j = 0; j < 32; j++) begin
      @(negedge clk);
      cfg_col_en = 32'd1 << j;
      cfg_data = v;
      v = mulx(v, poly, n);
    end
    @(negedge clk);
    cfg_col_en = '0;
    for (int i = 0; i < 3; i++) begin
      cfg_data = next_rand();   // R2: no column enabled, must not stick
      @(negedge clk);
    end
  endtask

  task automatic run_frame(input logic [31:0] poly, input int n, input logic [31:0] init,
                           input int nwords, input int last_bytes, input bit merge, input bit gap);
    logic [31:0] refv;
    logic [31:0] held;
    refv = init & wmask(n);
    init_value = init;
    @(negedge clk);
    if (!merge) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(crc_out == refv, "R4 seed visible", crc_out, refv);
    end
    for (int w = 0; w < nwords; w++) begin
      logic [31:0] d;
      int kb;
      d = next_rand();
      kb = (w == nwords - 1) ? last_bytes : 4;
      in_valid = 1'b1;
      in_last = (w == nwords - 1);
      in_bytes_m1 = 2'(kb - 1);
      in_data = d;
      start = merge && (w == 0);
      refv = ref_bits(refv, poly, n, d, 8 * kb);
      @(negedge clk);
      in_valid = 1'b0;
      in_last = 1'b0;
      start = 1'b0;
      in_data = next_rand();
      if (w == nwords - 1) begin
        check(crc_done == 1'b1, "R8 done after last", 32'(crc_done), 32'd1);
        if (last_bytes != 4)
          check(crc_out == refv, "R7 partial last word", crc_out, refv);
        else if (merge)
          check(crc_out == refv, "R5 start with word", crc_out, refv);
        else
          check(crc_out == refv, "R1 full words", crc_out, refv);
        check((crc_out & ~wmask(n)) == 0, "R6 width mask", crc_out, crc_out & wmask(n));
        @(negedge clk);
        check(crc_done == 1'b0, "R8 done one cycle", 32'(crc_done), 32'd0);
      end else begin
        check(crc_out == refv, "R1 mid-message remainder", crc_out, refv);
        if (gap) begin
          held = crc_out;
          in_last = 1'b1;       // ignored: in_valid low
          @(negedge clk);
          in_last = 1'b0;
          check(crc_out == held, "R3 idle hold", crc_out, held);
          check(crc_done == 1'b0, "R3 in_last ignored", 32'(crc_done), 32'd0);
        end
      end
    end
  endtask

  task automatic run_poly(input logic [31:0] poly, input int n, input logic [31:0] init);
    configure(poly, n);
    for (int lb = 1; lb <= 4; lb++) begin
      for (int nw = 1; nw <= 3; nw++) begin
        run_frame(poly, n, init, nw, lb, nw == 2, nw == 3);
      end
    end
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_col_en = '0;
    cfg_data = '0;
    crc_len_m1 = 5'd31;
    init_value = '0;
    start = 1'b0;
    in_valid = 1'b0;
    in_last = 1'b0;
    in_bytes_m1 = 2'd3;
    in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(crc_out == 32'd0, "R9 reset remainder", crc_out, 32'd0);
    check(crc_done == 1'b0, "R9 reset done", 32'(crc_done), 32'd0);
    // R9: unprogrammed grid, full word, width 32
    init_value = 32'h12345678;
    start = 1'b1;
    in_valid = 1'b1;
    in_last = 1'b1;
    in_data = 32'hDEADBEEF;
    @(negedge clk);
    start = 1'b0;
    in_valid = 1'b0;
    in_last = 1'b0;
    check(crc_out == 32'd0, "R9 cleared cells", crc_out, 32'd0);

    run_poly(32'h04C11DB7, 32, 32'hFFFFFFFF);
    run_poly(32'h00001021, 16, 32'h0000FFFF);
    run_poly(32'h00000007, 8,  32'h00000000);
    run_poly(32'h00000005, 5,  32'hFFFFFFFF);  // R6: seed bits above width dropped

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule